// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for the instruction currently in the execute stage of a five-stage in-order integer pipeline, where each of its two ALU operands should come from. It compares the two source register numbers of that instruction against the destination register numbers of the two older instructions still in flight: the one in the memory stage (the EX/MEM producer) and the one in the writeback stage (the MEM/WB producer). It takes each producer's register-write enable into account.

For each operand it drives a 2-bit select for the operand mux. The select picks the register-file value, the EX/MEM ALU result, or the MEM/WB writeback value. The younger producer always wins. Register zero is never bypassed. A producer that does not write a register is ignored. The two operands are decided separately.

The decision logic is purely combinational. The top level captures the decision in a register so that the result is one clean clocked value per cycle, with synchronous active-high reset.

Top module: `fwd_ctrl`

## Requirements
- R1: While reset is high at a clock edge, both selects become 00 (register file) after that edge.
- R2: When the EX/MEM producer has its write enable set, a nonzero destination, and a destination equal to an operand's source, that operand's select is 10.
- R3: When only the MEM/WB producer meets those conditions (write enable set, nonzero destination equal to the source), the operand's select is 01.
- R4: When both producers match the same source, the select is 10, because the younger EX/MEM result takes priority.
- R5: A producer whose write enable is clear never causes a bypass, even when its destination matches. If the other producer matches, that producer's code is used.
- R6: A destination of register 0 never causes a bypass. The select stays 00 unless the other producer matches a nonzero source.
- R7: Operand A (compared with src_a) and operand B (compared with src_b) are decided independently. In one cycle A may be 10 while B is 01.
- R8: When neither producer matches, the select is 00. A producer three or more instructions older is served by the register file.
- R9: Each select reflects the inputs sampled at the most recent rising clock edge. It keeps that value until the next edge, whatever the inputs do in between.
- R10: A select never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 5 | First source register of the execute-stage instruction |
| src_b | input | 5 | Second source register of the execute-stage instruction |
| exm_wen | input | 1 | Register-write enable of the EX/MEM producer |
| exm_rd | input | 5 | Destination register of the EX/MEM producer |
| mwb_wen | input | 1 | Register-write enable of the MEM/WB producer |
| mwb_rd | input | 5 | Destination register of the MEM/WB producer |
| sel_a | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| sel_b | output | 2 | Operand B source, same encoding |

## Verification
Both selects are due exactly one rising edge after a set of inputs is applied. The comparison itself adds no cycles; only the output register does. The bench drives each input set on a falling edge, lets one rising edge capture it, and compares at the following falling edge. For R9 it also changes the inputs just after a falling edge and checks before the next rising edge that the outputs still show the previous decision.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_W   = 5;
    localparam int NUM_OPS = 2;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MWB     = 2'b01,
        SRC_EXM     = 2'b10
    } op_src_e;

    typedef struct packed {
        logic             wen;
        logic [REG_W-1:0] rd;
    } producer_t;

    // A producer can supply a source if it writes a real register that equals it.
    function automatic logic can_supply(producer_t p, logic [REG_W-1:0] src);
        return p.wen && (p.rd != '0) && (p.rd == src);
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
(
    input  producer_t        prod,
    input  logic [REG_W-1:0] src,
    output logic             hit
);

    always_comb begin
        hit = can_supply(prod, src);
    end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic    hit_young,
    input  logic    hit_old,
    output op_src_e sel
);

    always_comb begin
        if (hit_young)
            sel = SRC_EXM;
        else if (hit_old)
            sel = SRC_MWB;
        else
            sel = SRC_REGFILE;
    end

    // R10
    always_comb begin
        sel_legal_chk: assert (sel != op_src_e'(2'b11) || $isunknown({hit_young, hit_old}));
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic [REG_W-1:0] src [NUM_OPS],
    input  producer_t        exm,
    input  producer_t        mwb,
    output op_src_e          sel [NUM_OPS]
);

    logic hit_exm [NUM_OPS];
    logic hit_mwb [NUM_OPS];

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        fwd_match u_exm_match (
            .prod (exm),
            .src  (src[op]),
            .hit  (hit_exm[op])
        );
        fwd_match u_mwb_match (
            .prod (mwb),
            .src  (src[op]),
            .hit  (hit_mwb[op])
        );
        fwd_pick u_pick (
            .hit_young (hit_exm[op]),
            .hit_old   (hit_mwb[op]),
            .sel       (sel[op])
        );
    end

endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
    import fwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             exm_wen,
    input  logic [REG_W-1:0] exm_rd,
    input  logic             mwb_wen,
    input  logic [REG_W-1:0] mwb_rd,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b
);

    logic [REG_W-1:0] src_arr [NUM_OPS];
    op_src_e          sel_d   [NUM_OPS];
    op_src_e          sel_q   [NUM_OPS];
    producer_t        exm_p;
    producer_t        mwb_p;
    logic             live_q;

    always_comb begin
        src_arr[0] = src_a;
        src_arr[1] = src_b;
        exm_p      = '{wen: exm_wen, rd: exm_rd};
        mwb_p      = '{wen: mwb_wen, rd: mwb_rd};
    end

    fwd_unit u_unit (
        .src (src_arr),
        .exm (exm_p),
        .mwb (mwb_p),
        .sel (sel_d)
    );

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[op] <= SRC_REGFILE;
            else
                sel_q[op] <= sel_d[op];
        end
    end

    // Marks that the previous edge was a normal capture edge, not a reset edge.
    always_ff @(posedge clk) begin
        if (rst)
            live_q <= 1'b0;
        else
            live_q <= 1'b1;
    end

    assign sel_a = sel_q[0];
    assign sel_b = sel_q[1];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sel_a == 2'b00 && sel_b == 2'b00));

    // R2
    exm_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (exm_wen && exm_rd != '0 && exm_rd == src_a) |=> (sel_a == 2'b10));

    // R4
    young_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (exm_wen && mwb_wen && exm_rd == mwb_rd && exm_rd != '0 && src_b == exm_rd)
        |=> (sel_b == 2'b10));

    // R5
    no_writer_chk: assert property (@(posedge clk) disable iff (rst)
        (!exm_wen && !mwb_wen) |=> (sel_a == 2'b00 && sel_b == 2'b00));

    // R6
    zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (exm_rd == '0 && mwb_rd == '0) |=> (sel_a == 2'b00 && sel_b == 2'b00));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (sel_a == $past(sel_d[0]) && sel_b == $past(sel_d[1])));

    // R10
    legal_out_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'b11 && sel_b != 2'b11));

endmodule

// File: tb/fwd_ctrl_bench.sv
`timescale 1ns/1ps
module fwd_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] src_a, src_b, exm_rd, mwb_rd;
    logic       exm_wen, mwb_wen;
    logic [1:0] sel_a, sel_b;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    fwd_ctrl u_fwd_ctrl (
        .clk     (clk),
        .rst     (rst),
        .src_a   (src_a),
        .src_b   (src_b),
        .exm_wen (exm_wen),
        .exm_rd  (exm_rd),
        .mwb_wen (mwb_wen),
        .mwb_rd  (mwb_rd),
        .sel_a   (sel_a),
        .sel_b   (sel_b)
    );

    function automatic logic [1:0] want_sel(logic [4:0] src, logic ew, logic [4:0] er,
                                            logic mw, logic [4:0] mr);
        if (ew && er != 0 && er == src) return 2'b10;
        if (mw && mr != 0 && mr == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string tag_of(logic [4:0] src, logic ew, logic [4:0] er,
                                     logic mw, logic [4:0] mr);
        logic e_hit = ew && er != 0 && er == src;
        logic m_hit = mw && mr != 0 && mr == src;
        if (e_hit && m_hit) return "R4";
        if (e_hit)          return "R2";
        if (m_hit)          return "R3";
        if ((er == src && (!ew || er == 0)) || (mr == src && (!mw || mr == 0))) return "R5/R6";
        return "R8";
    endfunction

    task automatic check(string req, logic [1:0] got, logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic drive(logic [4:0] a, logic [4:0] b, logic ew, logic [4:0] er,
                         logic mw, logic [4:0] mr);
        @(negedge clk);
        src_a = a; src_b = b; exm_wen = ew; exm_rd = er; mwb_wen = mw; mwb_rd = mr;
        @(negedge clk);
    endtask

    task automatic step(string req, logic [4:0] a, logic [4:0] b, logic ew, logic [4:0] er,
                        logic mw, logic [4:0] mr);
        drive(a, b, ew, er, mw, mr);
        check({req, " opA"}, sel_a, want_sel(a, ew, er, mw, mr));
        check({req, " opB"}, sel_b, want_sel(b, ew, er, mw, mr));
    endtask

    initial begin
        rst = 1'b1;
        src_a = 5'd3; src_b = 5'd3; exm_wen = 1'b1; exm_rd = 5'd3; mwb_wen = 1'b1; mwb_rd = 5'd3;
        repeat (3) @(negedge clk);
        // R1: reset forces register-file selects even with matching inputs
        check("R1 opA", sel_a, 2'b00);
        check("R1 opB", sel_b, 2'b00);
        rst = 1'b0;

        // back-to-back dependence
        step("R2", 5'd2, 5'd5, 1'b1, 5'd2, 1'b0, 5'd0);
        // dependence two instructions apart
        step("R3", 5'd6, 5'd2, 1'b0, 5'd9, 1'b1, 5'd2);
        // repeated accumulate into one register
        step("R4", 5'd1, 5'd2, 1'b1, 5'd1, 1'b1, 5'd1);
        step("R4", 5'd1, 5'd1, 1'b1, 5'd1, 1'b1, 5'd1);
        // non-writing producers
        step("R5", 5'd3, 5'd3, 1'b0, 5'd3, 1'b0, 5'd3);
        step("R5", 5'd3, 5'd4, 1'b0, 5'd3, 1'b1, 5'd3);
        // register zero destinations
        step("R6", 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        step("R6", 5'd0, 5'd7, 1'b1, 5'd0, 1'b1, 5'd7);
        // independent operands
        step("R7", 5'd4, 5'd7, 1'b1, 5'd4, 1'b1, 5'd7);
        step("R7", 5'd7, 5'd4, 1'b1, 5'd4, 1'b1, 5'd7);
        // no match
        step("R8", 5'd10, 5'd11, 1'b1, 5'd12, 1'b1, 5'd13);

        // R9: outputs hold until the next rising edge
        drive(5'd8, 5'd9, 1'b1, 5'd8, 1'b1, 5'd9);
        src_a = 5'd1; src_b = 5'd1; exm_wen = 1'b0; mwb_wen = 1'b0;
        #5;
        check("R9 hold opA", sel_a, 2'b10);
        check("R9 hold opB", sel_b, 2'b01);
        @(negedge clk);
        check("R9 update opA", sel_a, 2'b00);
        check("R9 update opB", sel_b, 2'b00);

        // constrained random: small register range to make matches frequent
        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a  = 5'($urandom % 5);
            logic [4:0] b  = 5'($urandom % 5);
            logic [4:0] er = 5'($urandom % 5);
            logic [4:0] mr = 5'($urandom % 5);
            logic       ew = 1'($urandom % 4 != 0);
            logic       mw = 1'($urandom % 4 != 0);
            drive(a, b, ew, er, mw, mr);
            check({tag_of(a, ew, er, mw, mr), " rand opA"}, sel_a, want_sel(a, ew, er, mw, mr));
            check({tag_of(b, ew, er, mw, mr), " rand opB"}, sel_b, want_sel(b, ew, er, mw, mr));
            // R10: code 11 is never produced
            n_checks++;
            if (sel_a == 2'b11 || sel_b == 2'b11) begin
                n_errors++;
                $display("FAIL R10: got %b/%b expected not 11", sel_a, sel_b);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule